// File: doc/BRIEF.md
# Relocating DMA Register Access Router

This block sits between a CPU-side register port and a simple peripheral I/O port. Every CPU access names a legacy DMA channel (0 to 7) and a register index within that channel (0 to 15). When that channel has been marked as distributed, the block forwards the access to the peripheral bus. The target address is placed inside one of two 64-byte-aligned windows: one window serves the lower channel group (0 to 3) and the other serves the upper group (5 to 7). Channel 4 never takes part. Accesses to channels that are not marked go to a small local register stub, which stands in for the controller's own registers.

The same CPU port also reaches four configuration registers: the two window bases, the per-channel enable mask and an alternate-access bit. Setting the alternate-access bit turns all forwarding off. It also opens the stub's write-only registers for reading and its read-only registers for writing, so software can save and restore the controller state around a power-down.

The controller follows a three-state machine. From ST_IDLE, an accepted request takes one of two paths: a forwarded access goes to ST_IO, and a local or configuration access goes straight to ST_RESP. ST_IO holds the peripheral request until the peripheral acknowledges, then moves to ST_RESP. ST_RESP drives a one-cycle ready pulse and always returns to ST_IDLE. Requests are accepted only in ST_IDLE.

Top module: `ddma_redirect`

## Requirements
- R1: After reset, the enable mask, both window bases and the alternate-access bit are zero, and configuration reads return zero. Configuration space is selected with cpu_cfg=1; cpu_reg value 0 selects the lower-group base, 1 the upper-group base, 2 the mask (bit n for channel n) and 3 the alternate-access bit (bit 0).
- R2: A base write discards data bits [5:0], and a read of a base returns those bits as zero.
- R3: A forwarded access drives io_addr = base + 16*slot + register index. The slot is 0, 1, 2, 3 for channels 0, 1, 2, 3 with the lower base, and 0, 1, 2 for channels 5, 6, 7 with the upper base.
- R4: Channel 4 is never forwarded, and mask bit 4 always reads as zero.
- R5: An access to a channel whose mask bit is clear goes to the local stub and raises no io_req.
- R6: A forwarded access raises io_req, with io_we and io_wdata taken from the CPU request. io_req, io_addr and io_we stay steady until io_ack is seen.
- R7: A forwarded read returns the io_rdata sampled with io_ack. cpu_ready rises in the cycle after the acknowledge and not before it.
- R8: While the alternate-access bit is set, no channel is forwarded.
- R9: Local registers 0 to 7 of each channel are write-only. Outside alternate-access mode they read as zero; in that mode they return the stored value.
- R10: Local registers 8 to 15 are read-only. Writes to them are ignored outside alternate-access mode and take effect inside it.
- R11: Only one access is outstanding. A cpu_req that arrives while an access is pending is dropped without effect.
- R12: A local or configuration access raises cpu_ready for one cycle, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, one cycle wide |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_cfg | input | 1 | 1 = configuration register, 0 = DMA channel register |
| cpu_chan | input | 3 | DMA channel number |
| cpu_reg | input | 4 | Register index within the channel, or configuration select |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | Access complete pulse |
| io_req | output | 1 | Peripheral access request |
| io_we | output | 1 | Peripheral write strobe |
| io_addr | output | 16 | Relocated peripheral I/O address |
| io_wdata | output | 16 | Peripheral write data |
| io_rdata | input | 16 | Peripheral read data |
| io_ack | input | 1 | Peripheral acknowledge |

## Verification
The in-RTL properties check every cycle that the peripheral request and its address stay steady until acknowledged, that ready is a single pulse and never overlaps a pending request, that a read's ready follows the acknowledge, and that channel 4 or alternate-access mode never starts a peripheral cycle. Only the directed scenarios can show the actual relocated address values, the read data path, the alignment masking, the save/restore behaviour of the stub's register classes, and that a request dropped while busy really leaves no trace.

// File: rtl/ddma_pkg.sv
package ddma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IO,
        ST_RESP
    } ddma_state_e;

    localparam int unsigned SEL_BASE_LO = 0;
    localparam int unsigned SEL_BASE_HI = 1;
    localparam int unsigned SEL_MASK    = 2;
    localparam int unsigned SEL_ALT     = 3;

    localparam int unsigned SKIP_CH     = 4;
    localparam int unsigned LO_GROUP_N  = 4;
    localparam int unsigned HI_FIRST_CH = 5;
endpackage

// File: rtl/ddma_cfg.sv
module ddma_cfg #(
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 16,
    parameter int unsigned NCH      = 8,
    parameter int unsigned SLOT_LSB = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     sel,
    input  logic [DW-1:0]  wdata,
    output logic [AW-1:0]  base_lo,
    output logic [AW-1:0]  base_hi,
    output logic [NCH-1:0] dist_mask,
    output logic           alt_mode,
    output logic [DW-1:0]  rdata
);
    import ddma_pkg::*;

    localparam int unsigned BW = AW - SLOT_LSB;

    logic [BW-1:0] lo_q, hi_q;
    logic          alt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            alt_q <= 1'b0;
        end else if (wr_en) begin
            if (sel == 2'(SEL_BASE_LO)) lo_q  <= wdata[AW-1:SLOT_LSB];
            if (sel == 2'(SEL_BASE_HI)) hi_q  <= wdata[AW-1:SLOT_LSB];
            if (sel == 2'(SEL_ALT))     alt_q <= wdata[0];
        end
    end

    // one enable flop per channel; the skipped channel has none
    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_mask
            if (gi == SKIP_CH) begin : g_skip
                assign dist_mask[gi] = 1'b0;
            end else begin : g_bit
                logic bit_q;
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        bit_q <= 1'b0;
                    else if (wr_en && sel == 2'(SEL_MASK))
                        bit_q <= wdata[gi];
                end
                assign dist_mask[gi] = bit_q;
            end
        end
    endgenerate

    assign base_lo  = {lo_q, {SLOT_LSB{1'b0}}};
    assign base_hi  = {hi_q, {SLOT_LSB{1'b0}}};
    assign alt_mode = alt_q;

    always_comb begin
        unique case (sel)
            2'(SEL_BASE_LO): rdata = DW'(base_lo);
            2'(SEL_BASE_HI): rdata = DW'(base_hi);
            2'(SEL_MASK):    rdata = DW'(dist_mask);
            default:         rdata = DW'(alt_q);
        endcase
    end
endmodule

// File: rtl/ddma_map.sv
module ddma_map #(
    parameter int unsigned AW    = 16,
    parameter int unsigned NCH   = 8,
    parameter int unsigned REG_W = 4,
    parameter int unsigned CH_W  = 3
) (
    input  logic [CH_W-1:0]  chan,
    input  logic [REG_W-1:0] reg_idx,
    input  logic [AW-1:0]    base_lo,
    input  logic [AW-1:0]    base_hi,
    input  logic [NCH-1:0]   dist_mask,
    input  logic             alt_mode,
    output logic             redirect,
    output logic [AW-1:0]    io_addr
);
    import ddma_pkg::*;

    logic [NCH-1:0] dist_ok;
    logic [1:0]     slot;
    logic [AW-1:0]  base_sel;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ok
            assign dist_ok[gi] = dist_mask[gi] & (gi != SKIP_CH);
        end
    endgenerate

    always_comb begin
        if (chan < CH_W'(LO_GROUP_N)) begin
            slot     = 2'(chan);
            base_sel = base_lo;
        end else begin
            slot     = 2'(chan - CH_W'(HI_FIRST_CH));
            base_sel = base_hi;
        end
        io_addr  = base_sel | AW'({slot, reg_idx});
        redirect = !alt_mode && dist_ok[chan];
    end
endmodule

// File: rtl/ddma_stub.sv
module ddma_stub #(
    parameter int unsigned DW    = 16,
    parameter int unsigned NCH   = 8,
    parameter int unsigned NREG  = 16,
    parameter int unsigned CH_W  = 3,
    parameter int unsigned REG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             wr,
    input  logic [CH_W-1:0]  chan,
    input  logic [REG_W-1:0] reg_idx,
    input  logic [DW-1:0]    wdata,
    input  logic             alt_mode,
    output logic [DW-1:0]    rdata
);
    localparam int unsigned DEPTH = NCH * NREG;
    localparam int unsigned IDX_W = CH_W + REG_W;

    logic [DW-1:0]    mem [DEPTH];
    logic [IDX_W-1:0] idx;
    logic             wr_only;
    logic             wr_allowed;

    assign idx        = {chan, reg_idx};
    assign wr_only    = reg_idx < REG_W'(NREG / 2);
    assign wr_allowed = wr_only || alt_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (acc_en && wr && wr_allowed) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = (!wr_only || alt_mode) ? mem[idx] : '0;
endmodule

// File: rtl/ddma_redirect.sv
module ddma_redirect #(
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 16,
    parameter int unsigned NCH   = 8,
    parameter int unsigned NREG  = 16,
    localparam int unsigned CH_W  = $clog2(NCH),
    localparam int unsigned REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic             cpu_cfg,
    input  logic [CH_W-1:0]  cpu_chan,
    input  logic [REG_W-1:0] cpu_reg,
    input  logic [DW-1:0]    cpu_wdata,
    output logic [DW-1:0]    cpu_rdata,
    output logic             cpu_ready,
    output logic             io_req,
    output logic             io_we,
    output logic [AW-1:0]    io_addr,
    output logic [DW-1:0]    io_wdata,
    input  logic [DW-1:0]    io_rdata,
    input  logic             io_ack
);
    import ddma_pkg::*;

    localparam int unsigned SLOT_LSB = REG_W + 2;

    ddma_state_e state_q, state_d;

    logic [AW-1:0]  base_lo, base_hi, map_addr;
    logic [NCH-1:0] dist_mask;
    logic           alt_mode, redirect;
    logic [DW-1:0]  cfg_rdata, stub_rdata;
    logic           accept, go_io;
    logic           io_we_q;
    logic [AW-1:0]  io_addr_q;
    logic [DW-1:0]  io_wdata_q, rdata_q;

    assign accept = (state_q == ST_IDLE) && cpu_req;
    assign go_io  = accept && !cpu_cfg && redirect;

    ddma_cfg #(.AW(AW), .DW(DW), .NCH(NCH), .SLOT_LSB(SLOT_LSB)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept && cpu_cfg && cpu_we),
        .sel       (cpu_reg[1:0]),
        .wdata     (cpu_wdata),
        .base_lo   (base_lo),
        .base_hi   (base_hi),
        .dist_mask (dist_mask),
        .alt_mode  (alt_mode),
        .rdata     (cfg_rdata)
    );

    ddma_map #(.AW(AW), .NCH(NCH), .REG_W(REG_W), .CH_W(CH_W)) map_i (
        .chan      (cpu_chan),
        .reg_idx   (cpu_reg),
        .base_lo   (base_lo),
        .base_hi   (base_hi),
        .dist_mask (dist_mask),
        .alt_mode  (alt_mode),
        .redirect  (redirect),
        .io_addr   (map_addr)
    );

    ddma_stub #(.DW(DW), .NCH(NCH), .NREG(NREG), .CH_W(CH_W), .REG_W(REG_W)) stub_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (accept && !cpu_cfg && !redirect),
        .wr       (cpu_we),
        .chan     (cpu_chan),
        .reg_idx  (cpu_reg),
        .wdata    (cpu_wdata),
        .alt_mode (alt_mode),
        .rdata    (stub_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = go_io ? ST_IO : ST_RESP;
            ST_IO:   if (io_ack) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // captured request and response data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_we_q    <= 1'b0;
            io_addr_q  <= '0;
            io_wdata_q <= '0;
            rdata_q    <= '0;
        end else begin
            if (go_io) begin
                io_we_q    <= cpu_we;
                io_addr_q  <= map_addr;
                io_wdata_q <= cpu_wdata;
            end else if (accept) begin
                if (cpu_we)       rdata_q <= '0;
                else if (cpu_cfg) rdata_q <= cfg_rdata;
                else              rdata_q <= stub_rdata;
            end
            if (state_q == ST_IO && io_ack)
                rdata_q <= io_we_q ? '0 : io_rdata;
        end
    end

    // outputs
    always_comb begin
        io_req    = (state_q == ST_IO);
        cpu_ready = (state_q == ST_RESP);
        io_we     = io_we_q;
        io_addr   = io_addr_q;
        io_wdata  = io_wdata_q;
        cpu_rdata = rdata_q;
    end

    // R6
    io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_ack |=> io_req);

    // R6
    io_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_ack |=> $stable(io_addr) && $stable(io_we));

    // R4
    chan4_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cpu_cfg && cpu_chan == CH_W'(SKIP_CH) |=> !io_req);

    // R8
    alt_no_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && alt_mode |=> !io_req);

    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R11
    single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_req |-> !cpu_ready);

    // R7
    read_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ready) && $past(io_req) |-> $past(io_ack));
endmodule

// File: tb/ddma_redirect_tb.sv
module ddma_redirect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_cfg = 1'b0;
    logic [2:0]  cpu_chan = '0;
    logic [3:0]  cpu_reg = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        io_req, io_we;
    logic [15:0] io_addr, io_wdata;
    logic [15:0] io_rdata = '0;
    logic        io_ack = 1'b0;

    int n_chk = 0, n_fail = 0;
    int resp_lat = 0, io_count = 0;
    logic [15:0] last_addr, last_wdata;
    logic        last_we;
    bit          done = 0;

    always #4 clk = ~clk;

    ddma_redirect dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_cfg(cpu_cfg), .cpu_chan(cpu_chan), .cpu_reg(cpu_reg),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_ack(io_ack)
    );

    // peripheral model
    initial begin
        forever begin
            @(negedge clk);
            if (io_req && !io_ack) begin
                repeat (resp_lat) @(negedge clk);
                last_addr  = io_addr;
                last_we    = io_we;
                last_wdata = io_wdata;
                io_count++;
                io_rdata   = io_addr ^ 16'h5A5A;
                io_ack     = 1'b1;
                @(negedge clk);
                io_ack     = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic cfg, input logic we, input logic [2:0] ch,
                          input logic [3:0] r, input logic [15:0] wd,
                          output logic [15:0] rd, output int cycles);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_cfg = cfg;
        cpu_chan = ch; cpu_reg = r; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        cycles = 1;
        while (!cpu_ready && cycles < 60) begin
            @(negedge clk);
            cycles++;
        end
        rd = cpu_rdata;
    endtask

    function automatic logic [15:0] exp_addr(input logic [15:0] blo, input logic [15:0] bhi,
                                             input int ch, input int r);
        // R3 slot rule
        if (ch < 4) return blo + 16'(ch * 16 + r);
        return bhi + 16'((ch - 5) * 16 + r);
    endfunction

    task automatic t_reset();
        logic [15:0] rd; int cy;
        for (int s = 0; s < 4; s++) begin
            access(1, 0, 0, 4'(s), 0, rd, cy);
            chk("R1 cfg reset value", rd, 0);
        end
    endtask

    task automatic t_cfg();
        logic [15:0] rd; int cy;
        access(1, 1, 0, 0, 16'h12FF, rd, cy);
        chk("R12 cfg write ready latency", cy, 1);
        access(1, 0, 0, 0, 0, rd, cy);
        chk("R2 lower base alignment", rd, 16'h12C0);
        access(1, 1, 0, 1, 16'h0347, rd, cy);
        access(1, 0, 0, 1, 0, rd, cy);
        chk("R2 upper base alignment", rd, 16'h0340);
        access(1, 1, 0, 2, 16'h00FF, rd, cy);
        access(1, 0, 0, 2, 0, rd, cy);
        chk("R4 mask bit 4 reads zero", rd, 16'h00EF);
    endtask

    task automatic t_map();
        logic [15:0] rd; int cy; int base_cnt;
        int chs[7] = '{0, 1, 2, 3, 5, 6, 7};
        int rgs[7] = '{3, 5, 10, 15, 0, 7, 2};
        for (int i = 0; i < 7; i++) begin
            resp_lat = i % 3;
            base_cnt = io_count;
            access(0, 1, 3'(chs[i]), 4'(rgs[i]), 16'hC000 + 16'(i), rd, cy);
            chk("R3 relocated address", last_addr, exp_addr(16'h12C0, 16'h0340, chs[i], rgs[i]));
            chk("R6 write strobe and data", {last_we, last_wdata}, {1'b1, 16'hC000 + 16'(i)});
            chk("R6 one peripheral cycle", io_count - base_cnt, 1);
            chk("R7 ready after ack", cy, resp_lat + 2);
        end
    endtask

    task automatic t_read();
        logic [15:0] rd; int cy;
        resp_lat = 3;
        access(0, 0, 6, 4'd9, 0, rd, cy);
        chk("R7 read data returned", rd, 16'h0359 ^ 16'h5A5A);
        chk("R7 read waits for ack", cy, 5);
        chk("R6 read strobe", last_we, 0);
        resp_lat = 0;
        access(0, 0, 3, 4'd1, 0, rd, cy);
        chk("R7 read data zero latency", rd, 16'h12F1 ^ 16'h5A5A);
    endtask

    task automatic t_chan4();
        logic [15:0] rd; int cy; int base_cnt;
        base_cnt = io_count;
        access(0, 1, 4, 4'd2, 16'h4444, rd, cy);
        chk("R4 channel 4 not forwarded", io_count - base_cnt, 0);
        chk("R12 local ready latency", cy, 1);
    endtask

    task automatic t_local();
        logic [15:0] rd; int cy; int base_cnt;
        access(1, 1, 0, 2, 16'h000F, rd, cy);
        base_cnt = io_count;
        access(0, 1, 6, 4'd1, 16'hBEEF, rd, cy);
        access(0, 0, 6, 4'd1, 0, rd, cy);
        chk("R5 undistributed channel stays local", io_count - base_cnt, 0);
        chk("R9 write-only reads zero", rd, 0);
        access(0, 1, 6, 4'd9, 16'h1111, rd, cy);
        access(0, 0, 6, 4'd9, 0, rd, cy);
        chk("R10 read-only write ignored", rd, 0);
    endtask

    task automatic t_alt();
        logic [15:0] rd; int cy; int base_cnt;
        access(1, 1, 0, 3, 16'h0001, rd, cy);
        base_cnt = io_count;
        access(0, 1, 0, 4'd2, 16'h7A7A, rd, cy);
        access(0, 0, 0, 4'd2, 0, rd, cy);
        chk("R8 distributed channel kept local", io_count - base_cnt, 0);
        chk("R9 write-only readable in alt", rd, 16'h7A7A);
        access(0, 0, 6, 4'd1, 0, rd, cy);
        chk("R9 saved value visible in alt", rd, 16'hBEEF);
        access(0, 1, 6, 4'd9, 16'h2222, rd, cy);
        access(1, 1, 0, 3, 16'h0000, rd, cy);
        access(0, 0, 6, 4'd9, 0, rd, cy);
        chk("R10 alt write to read-only kept", rd, 16'h2222);
        base_cnt = io_count;
        access(0, 1, 0, 4'd2, 16'h1234, rd, cy);
        chk("R8 forwarding resumes after alt", io_count - base_cnt, 1);
    endtask

    task automatic t_busy();
        logic [15:0] rd; int cy; int base_cnt;
        base_cnt = io_count;
        resp_lat = 6;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_cfg = 1'b0; cpu_chan = 3'd1; cpu_reg = 4'd4;
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_chan = 3'd6; cpu_reg = 4'd3; cpu_wdata = 16'h7777;
        @(negedge clk);
        cpu_req = 1'b0;
        cy = 3;
        while (!cpu_ready && cy < 60) begin
            @(negedge clk);
            cy++;
        end
        chk("R11 pending read data", cpu_rdata, 16'h12D4 ^ 16'h5A5A);
        chk("R11 latency unaffected", cy, 8);
        resp_lat = 0;
        access(1, 1, 0, 3, 16'h0001, rd, cy);
        access(0, 0, 6, 4'd3, 0, rd, cy);
        chk("R11 dropped write left no trace", rd, 0);
        chk("R11 single peripheral cycle", io_count - base_cnt, 1);
        access(1, 1, 0, 3, 16'h0000, rd, cy);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 no request after reset", {io_req, cpu_ready}, 0);
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_map();
        t_read();
        t_chan4();
        t_local();
        t_alt();
        t_busy();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule